// File: doc/BRIEF.md
# Sampled Key-Sequence Lock Detector

A synchronous Moore state machine samples a two-key input on each rising clock edge. Its release output rises only after a fixed run of four key codes has been sampled on four consecutive edges. A code that does not continue the run throws the progress away. A rest code (both keys released) always counts as a fresh first step, because it is also the first code of the run. This gives five reachable states: idle, three progress states and an open state.

Two builds can be chosen with a parameter. One is a hand-minimised three-flop machine that uses the state assignment idle=000, first=001, second=011, third=010, open=100, and whose output is the top state bit. The other is a three-bit step counter with a decoded synchronous reload. Both give the same output for every input stream. Any encoding that cannot be reached falls back to idle on the next edge.

Top module: `key_seq_lock`

## Requirements
- R1: While rst_ni is low, open_o is 0. After reset the machine is idle, so a run that does not begin with code 00 cannot open it.
- R2: The key code is key_i[1:0] = {first key, second key}. Sampling 00, 01, 01, 10 on four consecutive rising edges drives open_o to 1 in the period that follows the fourth edge.
- R3: open_o stays high for exactly one clock period and is low after the next edge unless a new full run has finished on that edge.
- R4: A sampled code that neither continues the run nor equals 00 returns the machine to idle.
- R5: Sampling 00 in any state, including partway through a run, moves the machine to the first-seen step.
- R6: A correct code held for an extra period is a violation. For example, 00, 01, 01, 01, 10 does not open.
- R7: From the open state, a sample of 00 starts a new run, so back-to-back runs open the lock once every four periods.
- R8: Key changes between clock edges have no effect. Only the value present at a rising edge matters.
- R9: The equation build (USE_COUNTER=0) and the counter build (USE_COUNTER=1) produce the same open_o for every input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to idle |
| key_i | input | 2 | Key code {first key, second key} |
| open_o | output | 1 | High for one period after a complete run |

## Verification
The hardest case to reach is one where the restart rule and run progress interleave. Examples are a 00 arriving in the third step, a held 01 at the second step, or a new run starting in the very period the lock is open. Plain random streams seldom produce these. The stimulus therefore sweeps every six-code stream after reset (4096 streams) and checks both builds against a reference that only asks whether the last four samples spell the run. Directed runs and narrow mid-period key glitches are added on top of the sweep.

// File: rtl/key_seq_pkg.sv
package key_seq_pkg;
  localparam int KEY_W   = 2;
  localparam int SEQ_LEN = 4;
  localparam int STAGE_W = 3;

  typedef logic [KEY_W-1:0] key_t;

  localparam key_t KEY_REST = 2'b00;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_FIRST  = 3'b001,
    ST_SECOND = 3'b011,
    ST_THIRD  = 3'b010,
    ST_OPEN   = 3'b100
  } stage_e;

  // code expected at run position idx
  function automatic key_t seq_code(input int unsigned idx);
    case (idx)
      0:       seq_code = 2'b00;
      1, 2:    seq_code = 2'b01;
      3:       seq_code = 2'b10;
      default: seq_code = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/key_seq_eqn_fsm.sv
module key_seq_eqn_fsm
  import key_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  key_t   key_i,
  output logic   open_o,
  output stage_e stage_o
);
  logic [STAGE_W-1:0] y_q, y_d;
  logic x1, x2, y1, y2, y3, bad;

  assign x1 = key_i[1];
  assign x2 = key_i[0];
  assign y1 = y_q[2];
  assign y2 = y_q[1];
  assign y3 = y_q[0];

  // 101/110/111 never reached; force idle
  assign bad = y1 & (y2 | y3);

  always_comb begin
    if (bad) begin
      y_d = '0;
    end else begin
      y_d[2] = x1 & ~x2 & y2 & ~y3;
      y_d[1] = ~x1 & x2 & y3;
      y_d[0] = (~x1 & ~x2) | (~x1 & ~y2 & y3);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_d;
  end

  assign open_o  = y1;
  assign stage_o = stage_e'(y_q);
endmodule

// File: rtl/key_seq_cnt_fsm.sv
module key_seq_cnt_fsm
  import key_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  key_t   key_i,
  output logic   open_o,
  output stage_e stage_o
);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_OPEN = CNT_W'(SEQ_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic hit, rest, in_run;

  assign in_run = cnt_q < CNT_OPEN;
  assign rest   = key_i == KEY_REST;
  assign hit    = in_run && (key_i == seq_code(32'(cnt_q)));

  always_comb begin
    if (cnt_q > CNT_OPEN) cnt_d = '0;
    else if (hit)         cnt_d = cnt_q + CNT_ONE;
    else if (rest)        cnt_d = CNT_ONE;
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign open_o = cnt_q == CNT_OPEN;

  always_comb begin
    case (cnt_q)
      CNT_W'(1): stage_o = ST_FIRST;
      CNT_W'(2): stage_o = ST_SECOND;
      CNT_W'(3): stage_o = ST_THIRD;
      CNT_OPEN:  stage_o = ST_OPEN;
      default:   stage_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/key_seq_lock.sv
module key_seq_lock
  import key_seq_pkg::*;
#(
  parameter bit USE_COUNTER = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  stage_e lock_stage;

  generate
    if (USE_COUNTER) begin : g_cnt
      key_seq_cnt_fsm u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .key_i   (key_i),
        .open_o  (open_o),
        .stage_o (lock_stage)
      );
    end else begin : g_eqn
      key_seq_eqn_fsm u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .key_i   (key_i),
        .open_o  (open_o),
        .stage_o (lock_stage)
      );
    end
  endgenerate
endmodule

// File: rtl/key_seq_lock_chk.sv
module key_seq_lock_chk
  import key_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [KEY_W-1:0] key_i,
  input logic             open_o,
  input stage_e           lock_stage
);
  // R1
  reset_closed_chk: assert property (@(posedge clk_i) !rst_ni |-> !open_o);

  // R2
  third_to_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_stage == ST_THIRD && key_i == 2'b10) |=> open_o);

  // R2
  open_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_i) == 2'b10);

  // R3
  one_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> !open_o);

  // R4
  first_wrong_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_stage == ST_FIRST && key_i[1]) |=> lock_stage == ST_IDLE);

  // R5
  rest_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_i == KEY_REST |=> lock_stage == ST_FIRST);

  // R6
  held_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_stage == ST_THIRD && key_i == 2'b01) |=> lock_stage == ST_IDLE);
endmodule

bind key_seq_lock key_seq_lock_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_i      (key_i),
  .open_o     (open_o),
  .lock_stage (lock_stage)
);

// File: tb/test_key_seq_lock.sv
`timescale 1ns/1ps
module test_key_seq_lock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] key_i = 2'b11;
  logic       open_eqn, open_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] hist = '0;
  int         nsamp = 0;

  always #2.5 clk_i = ~clk_i;

  key_seq_lock #(.USE_COUNTER(1'b0)) i_key_seq_lock (
    .clk_i (clk_i), .rst_ni (rst_ni), .key_i (key_i), .open_o (open_eqn));
  key_seq_lock #(.USE_COUNTER(1'b1)) i_key_seq_lock_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .key_i (key_i), .open_o (open_cnt));

  function automatic logic model_open();
    return (nsamp >= 4) && (hist == 8'b00_01_01_10);
  endfunction

  task automatic chk(input string req);
    logic exp;
    exp = model_open();
    checks++;
    if (open_eqn !== exp) begin
      errors++;
      $display("FAIL %s eqn build open_o=%b expected %b", req, open_eqn, exp);
    end
    checks++;
    if (open_cnt !== exp) begin
      errors++;
      $display("FAIL %s/R9 counter build open_o=%b expected %b", req, open_cnt, exp);
    end
  endtask

  // called 1 ns after an edge; key held to next edge, checked 1 ns after it
  task automatic apply(input logic [1:0] k, input string req);
    key_i = k;
    @(posedge clk_i);
    hist = {hist[5:0], k};
    nsamp++;
    #1;
    chk(req);
  endtask

  // narrow glitch g between edges, settling to k before the edge
  task automatic apply_glitch(input logic [1:0] k, input logic [1:0] g);
    key_i = g;
    #1;
    key_i = k;
    @(posedge clk_i);
    hist = {hist[5:0], k};
    nsamp++;
    #1;
    chk("R8");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(posedge clk_i);
    #1;
    nsamp = 0;
    hist = '0;
    chk("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    @(posedge clk_i);
    #1;
    do_reset();

    // R1: reset is idle, run without leading 00 stays closed
    apply(2'b01, "R1"); apply(2'b01, "R1"); apply(2'b10, "R1");

    // R2 basic run, R3 single period
    apply(2'b00, "R2"); apply(2'b01, "R2"); apply(2'b01, "R2"); apply(2'b10, "R2");
    apply(2'b11, "R3"); apply(2'b11, "R3");

    // R4 wrong code mid-run
    apply(2'b00, "R4"); apply(2'b01, "R4"); apply(2'b11, "R4");
    apply(2'b01, "R4"); apply(2'b10, "R4");

    // R5 early 00 restarts at first step
    apply(2'b00, "R5"); apply(2'b01, "R5"); apply(2'b00, "R5");
    apply(2'b01, "R5"); apply(2'b01, "R5"); apply(2'b10, "R5");

    // R6 held code
    apply(2'b00, "R6"); apply(2'b01, "R6"); apply(2'b01, "R6");
    apply(2'b01, "R6"); apply(2'b10, "R6");

    // R7 back-to-back runs
    for (int r = 0; r < 3; r++) begin
      apply(2'b00, "R7"); apply(2'b01, "R7"); apply(2'b01, "R7"); apply(2'b10, "R7");
    end

    // R8 mid-period glitches
    apply_glitch(2'b00, 2'b11); apply_glitch(2'b01, 2'b10);
    apply_glitch(2'b01, 2'b00); apply_glitch(2'b10, 2'b01);
    apply_glitch(2'b11, 2'b00); apply_glitch(2'b01, 2'b00);

    // R9 sweep of every six-code stream after reset
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int i = 5; i >= 0; i--) begin
        logic [11:0] sv;
        sv = 12'(s);
        apply(sv[2*i +: 2], "R9");
      end
    end

    // R9 long random stream biased toward the run codes
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      apply((r < 3) ? 2'b00 : (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : 2'b11, "R9");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule